// File: doc/BRIEF.md
# Multicycle Indirect-Call Processor Core

This block is the control unit and datapath of a small multicycle processor. It reads 16-bit instructions from a byte-wide memory one byte at a time, through an 8-bit memory data register, least significant byte first. Every instruction goes through a fixed six-cycle fetch phase. The only instruction it executes is an indirect subroutine call, opcode 0x9509. That call saves the address of the next instruction on a stack that grows downward, then jumps to the 16-bit address held in the Z register pair.

Any other opcode finishes when its fetch finishes. The next fetch follows at once. The register file holds 32 byte-wide registers, and Z is register 31 (high byte) joined to register 30 (low byte). A preload port writes Z so that a test environment can pick call targets. Debug outputs show the program counter, the stack pointer and the instruction register.

Memory is asynchronous to read. The address comes straight from the memory address register, and the returned byte is captured into the data register on the edge that ends a read cycle.

Top module: `icall_cpu`

## Requirements
- R1: While `rst` is high at a clock edge, the core sets the program counter to 0x0000 and the stack pointer to 0xFFFF. Both memory strobes stay low while `rst` is high.
- R2: A fetch lasts exactly 6 cycles. It issues one read at the starting program counter value P and one read at P+1. It then shows `dbg_ir` equal to {byte at P+1, byte at P} and `dbg_pc` equal to P+2.
- R3: An opcode other than 0x9509 causes no memory write and leaves the stack pointer unchanged. Such an opcode, including every value that differs from 0x9509 in a single bit, takes only the 6 fetch cycles before the next fetch begins.
- R4: Opcode 0x9509 adds an execute phase of exactly 7 cycles. After cycle 12 of the instruction the program counter still holds P+2. After cycle 13 it equals the value in Z.
- R5: The call makes exactly two writes. The low byte of the return address P+2 goes to the initial stack pointer S, and the high byte goes to S−1.
- R6: Each call lowers the stack pointer by exactly 2, one step per write. The stack pointer never moves in any other way, so nested calls stack their return addresses at successively lower addresses.
- R7: Driving `z_load` high at a clock edge loads `z_value[7:0]` into register 30 and `z_value[15:8]` into register 31. The next call jumps to that value, and the preload has no effect on an instruction that is not a call.
- R8: `mem_wr` is high only in the two push-write cycles of a call, and `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| z_load | input | 1 | Preload enable for the Z register pair |
| z_value | input | 16 | Preload value for Z (high byte to register 31) |
| mem_addr | output | 16 | Byte address from the memory address register |
| mem_wdata | output | 8 | Write data from the memory data register |
| mem_rdata | input | 8 | Read data from memory, combinational |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| dbg_pc | output | 16 | Program counter |
| dbg_sp | output | 16 | Stack pointer |
| dbg_ir | output | 16 | Instruction register |

## Verification
The bench builds the core with its defaults: 16-bit addresses, 8-bit data, 32 registers and the stack starting at 0xFFFF. It sweeps all sixteen single-bit neighbours of the call opcode, plus all-zero, to show that none of them is mistaken for a call. It then chains four nested calls to even and odd targets, so that the pushed return addresses include non-zero high bytes and the stack descends over eight bytes. It also asserts reset in the middle of a call's push sequence. The small default configuration puts every cycle of both phases within reach of exact per-cycle checks.

// File: rtl/icall_pkg.sv
package icall_pkg;

    // Micro-step sequencer phases: six fetch steps, seven call steps
    typedef enum logic [3:0] {
        S_F0, S_F1, S_F2, S_F3, S_F4, S_F5,
        S_E0, S_E1, S_E2, S_E3, S_E4, S_E5, S_E6
    } phase_e;

    // One micro-step's worth of datapath controls
    typedef struct packed {
        logic mar_pc;     // MAR <- PC
        logic mar_sp;     // MAR <- SP
        logic rd;         // memory read, MDR <- mem
        logic wr;         // memory write of MDR at MAR
        logic pc_inc;     // PC <- PC + 1
        logic ir_lo;      // IR low byte <- MDR
        logic ir_hi;      // IR high byte <- MDR
        logic mdr_pc_lo;  // MDR <- PC low byte
        logic mdr_pc_hi;  // MDR <- PC high byte
        logic sp_dec;     // SP <- SP - 1
        logic pc_z;       // PC <- Z
    } ctrl_t;

endpackage

// File: rtl/icall_regfile.sv
module icall_regfile
    import icall_pkg::*;
#(
    parameter int DW    = 8,
    parameter int NREGS = 32,
    parameter int ZLO   = 30,
    parameter int ZHI   = 31
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            z_en,
    input  logic [2*DW-1:0] z_val,
    output logic [2*DW-1:0] z_out
);

    logic [DW-1:0] r_q [NREGS];
    logic [DW-1:0] r_d [NREGS];

    always_comb begin
        for (int i = 0; i < NREGS; i++) begin
            r_d[i] = r_q[i];
        end
        if (z_en) begin
            r_d[ZLO] = z_val[DW-1:0];
            r_d[ZHI] = z_val[2*DW-1:DW];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) begin
                r_q[i] <= '0;
            end
        end else begin
            r_q <= r_d;
        end
    end

    assign z_out = {r_q[ZHI], r_q[ZLO]};

    // R7: preload lands in the pair on the next edge
    p_z_preload_r7: assert property (@(posedge clk) disable iff (rst)
        z_en |=> (z_out == $past(z_val)));

endmodule

// File: rtl/icall_seq.sv
module icall_seq
    import icall_pkg::*;
#(
    parameter int          IW      = 16,
    parameter logic [15:0] OP_CALL = 16'h9509
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] opcode_next,
    output ctrl_t         ctrl
);

    typedef struct packed {
        phase_e phase;
    } seq_s;

    seq_s q, d;

    always_comb begin
        d = q;
        case (q.phase)
            S_F0: d.phase = S_F1;
            S_F1: d.phase = S_F2;
            S_F2: d.phase = S_F3;
            S_F3: d.phase = S_F4;
            S_F4: d.phase = S_F5;
            S_F5: d.phase = (opcode_next == IW'(OP_CALL)) ? S_E0 : S_F0;
            S_E0: d.phase = S_E1;
            S_E1: d.phase = S_E2;
            S_E2: d.phase = S_E3;
            S_E3: d.phase = S_E4;
            S_E4: d.phase = S_E5;
            S_E5: d.phase = S_E6;
            default: d.phase = S_F0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.phase <= S_F0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        ctrl = '0;
        case (q.phase)
            S_F0: ctrl.mar_pc = 1'b1;
            S_F1: begin ctrl.rd = !rst; ctrl.pc_inc = 1'b1; end
            S_F2: ctrl.ir_lo = 1'b1;
            S_F3: ctrl.mar_pc = 1'b1;
            S_F4: begin ctrl.rd = !rst; ctrl.pc_inc = 1'b1; end
            S_F5: ctrl.ir_hi = 1'b1;
            S_E0: ctrl.mar_sp = 1'b1;
            S_E1: ctrl.mdr_pc_lo = 1'b1;
            S_E2: begin ctrl.wr = !rst; ctrl.sp_dec = 1'b1; end
            S_E3: ctrl.mar_sp = 1'b1;
            S_E4: ctrl.mdr_pc_hi = 1'b1;
            S_E5: begin ctrl.wr = !rst; ctrl.sp_dec = 1'b1; end
            S_E6: ctrl.pc_z = 1'b1;
            default: ctrl = '0;
        endcase
    end

    // R8: read and write strobes are exclusive
    p_rw_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        !(ctrl.rd && ctrl.wr));

    // R3: the last fetch step leads either to a new fetch or to the call
    p_fetch_exit_r3: assert property (@(posedge clk) disable iff (rst)
        (q.phase == S_F5) |=> (q.phase == S_F0 || q.phase == S_E0));

    // R4: the call's final step always returns to fetch
    p_call_return_r4: assert property (@(posedge clk) disable iff (rst)
        (q.phase == S_E6) |=> (q.phase == S_F0));

endmodule

// File: rtl/icall_datapath.sv
module icall_datapath
    import icall_pkg::*;
#(
    parameter int          AW      = 16,
    parameter int          DW      = 8,
    parameter logic [15:0] SP_INIT = 16'hFFFF
) (
    input  logic          clk,
    input  logic          rst,
    input  ctrl_t         ctrl,
    input  logic [DW-1:0] mem_rdata,
    input  logic [AW-1:0] z_val,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] sp,
    output logic [AW-1:0] mar,
    output logic [DW-1:0] mdr,
    output logic [2*DW-1:0] ir,
    output logic [2*DW-1:0] opcode_next
);

    localparam int IW = 2 * DW;

    typedef struct packed {
        logic [AW-1:0] pc;
        logic [AW-1:0] sp;
        logic [AW-1:0] mar;
        logic [DW-1:0] mdr;
        logic [IW-1:0] ir;
    } dp_s;

    dp_s q, d;

    always_comb begin
        d = q;
        if (ctrl.mar_pc)    d.mar = q.pc;
        if (ctrl.mar_sp)    d.mar = q.sp;
        if (ctrl.rd)        d.mdr = mem_rdata;
        if (ctrl.mdr_pc_lo) d.mdr = q.pc[DW-1:0];
        if (ctrl.mdr_pc_hi) d.mdr = q.pc[AW-1:AW-DW];
        if (ctrl.pc_inc)    d.pc  = q.pc + AW'(1);
        if (ctrl.pc_z)      d.pc  = z_val;
        if (ctrl.ir_lo)     d.ir[DW-1:0] = q.mdr;
        if (ctrl.ir_hi)     d.ir[IW-1:DW] = q.mdr;
        if (ctrl.sp_dec)    d.sp  = q.sp - AW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            q.sp <= AW'(SP_INIT);
        end else begin
            q <= d;
        end
    end

    assign pc          = q.pc;
    assign sp          = q.sp;
    assign mar         = q.mar;
    assign mdr         = q.mdr;
    assign ir          = q.ir;
    assign opcode_next = {q.mdr, q.ir[DW-1:0]};

    // R6: the stack pointer only ever steps down by one
    p_sp_step_down_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && q.sp != $past(q.sp)) |-> (q.sp == $past(q.sp) - AW'(1)));

    // R2: each read cycle advances the program counter by one
    p_pc_after_read_r2: assert property (@(posedge clk) disable iff (rst)
        ctrl.rd |=> (q.pc == $past(q.pc) + AW'(1)));

endmodule

// File: rtl/icall_cpu.sv
module icall_cpu
    import icall_pkg::*;
#(
    parameter int          AW      = 16,
    parameter int          DW      = 8,
    parameter int          NREGS   = 32,
    parameter logic [15:0] SP_INIT = 16'hFFFF,
    parameter logic [15:0] OP_CALL = 16'h9509
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          z_load,
    input  logic [AW-1:0] z_value,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] dbg_pc,
    output logic [AW-1:0] dbg_sp,
    output logic [2*DW-1:0] dbg_ir
);

    localparam int IW  = 2 * DW;
    localparam int ZHI = NREGS - 1;
    localparam int ZLO = NREGS - 2;

    ctrl_t         ctrl;
    logic [IW-1:0] opcode_next;
    logic [AW-1:0] z_out;

    icall_seq #(
        .IW      (IW),
        .OP_CALL (OP_CALL)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .opcode_next (opcode_next),
        .ctrl        (ctrl)
    );

    icall_regfile #(
        .DW    (DW),
        .NREGS (NREGS),
        .ZLO   (ZLO),
        .ZHI   (ZHI)
    ) u_rf (
        .clk   (clk),
        .rst   (rst),
        .z_en  (z_load),
        .z_val (z_value),
        .z_out (z_out)
    );

    icall_datapath #(
        .AW      (AW),
        .DW      (DW),
        .SP_INIT (SP_INIT)
    ) u_dp (
        .clk         (clk),
        .rst         (rst),
        .ctrl        (ctrl),
        .mem_rdata   (mem_rdata),
        .z_val       (z_out),
        .pc          (dbg_pc),
        .sp          (dbg_sp),
        .mar         (mem_addr),
        .mdr         (mem_wdata),
        .ir          (dbg_ir),
        .opcode_next (opcode_next)
    );

    assign mem_rd = ctrl.rd;
    assign mem_wr = ctrl.wr;

    // R5: every push writes at the current stack pointer
    p_wr_at_sp_r5: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (mem_addr == dbg_sp));

    // R1: strobes stay quiet while reset is held
    p_quiet_reset_r1: assert property (@(posedge clk)
        rst |-> (!mem_rd && !mem_wr));

endmodule

// File: tb/icall_cpu_tb.sv
module icall_cpu_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        z_load = 1'b0;
    logic [15:0] z_value = '0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        mem_rd, mem_wr;
    logic [15:0] dbg_pc, dbg_sp, dbg_ir;

    logic [7:0]  mem [1024];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int rd_n   = 0;
    int wr_n   = 0;
    int rw_clash = 0;
    logic [15:0] rd_log [256];
    logic [15:0] wr_a   [256];
    logic [7:0]  wr_d   [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = mem[mem_addr[9:0]];

    icall_cpu u_dut (
        .clk       (clk),
        .rst       (rst),
        .z_load    (z_load),
        .z_value   (z_value),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .dbg_pc    (dbg_pc),
        .dbg_sp    (dbg_sp),
        .dbg_ir    (dbg_ir)
    );

    // Bus monitor: logs reads and writes seen at each edge
    always @(posedge clk) begin
        if (!rst) begin
            if (mem_rd) begin
                rd_log[rd_n % 256] <= mem_addr;
                rd_n <= rd_n + 1;
            end
            if (mem_wr) begin
                wr_a[wr_n % 256] <= mem_addr;
                wr_d[wr_n % 256] <= mem_wdata;
                wr_n <= wr_n + 1;
            end
            if (mem_rd && mem_wr) rw_clash <= rw_clash + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put16(input int addr, input logic [15:0] val);
        mem[addr]     = val[7:0];
        mem[addr + 1] = val[15:8];
    endtask

    // Runs one instruction from the current PC; Z is preloaded in its first cycle
    task automatic run_instr(input logic [15:0] op, input logic [15:0] znew);
        logic [15:0] pc0, sp0, ret;
        int r0, w0;
        bit is_call;
        pc0 = dbg_pc;
        sp0 = dbg_sp;
        r0  = rd_n;
        w0  = wr_n;
        is_call = (op == 16'h9509);
        ret = pc0 + 16'd2;
        z_load  = 1'b1;
        z_value = znew;
        @(posedge clk); #1;
        z_load = 1'b0;
        repeat (5) @(posedge clk);
        #1;
        chk("R2 ir after 6 cycles", dbg_ir, op);
        chk("R2 pc advanced by 2", dbg_pc, ret);
        chk("R2 read count", rd_n - r0, 2);
        chk("R2 first read addr", rd_log[r0 % 256], pc0);
        chk("R2 second read addr", rd_log[(r0 + 1) % 256], pc0 + 16'd1);
        if (!is_call) begin
            chk("R3 sp unchanged", dbg_sp, sp0);
            chk("R3 no write", wr_n - w0, 0);
        end else begin
            repeat (6) @(posedge clk);
            #1;
            chk("R4 pc held at cycle 12", dbg_pc, ret);
            chk("R6 sp down by 2", dbg_sp, sp0 - 16'd2);
            @(posedge clk); #1;
            chk("R4 R7 pc equals Z at cycle 13", dbg_pc, znew);
            chk("R8 write count", wr_n - w0, 2);
            chk("R5 low byte addr", wr_a[w0 % 256], sp0);
            chk("R5 low byte data", wr_d[w0 % 256], ret[7:0]);
            chk("R5 high byte addr", wr_a[(w0 + 1) % 256], sp0 - 16'd1);
            chk("R5 high byte data", wr_d[(w0 + 1) % 256], ret[15:8]);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_LIMIT) begin
            fails = fails + 1;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        // Single-bit neighbours of the call opcode, then all-zero
        for (int k = 0; k < 16; k++) put16(2 * k, 16'h9509 ^ (16'h1 << k));
        put16(32, 16'h0000);
        put16(34, 16'h9509);
        put16(16'h100, 16'h9509);
        put16(16'h2F0, 16'h0000);
        put16(16'h2F2, 16'h9509);
        put16(16'h381, 16'h9509);
        put16(16'h3A0, 16'h9509);

        // R1: reset state
        repeat (2) @(posedge clk);
        #1;
        chk("R1 reset pc", dbg_pc, 16'h0000);
        chk("R1 reset sp", dbg_sp, 16'hFFFF);
        chk("R1 no read in reset", mem_rd, 1'b0);
        chk("R1 no write in reset", mem_wr, 1'b0);
        rst = 1'b0;

        // R3 R7: neighbours are no-ops; preloaded Z has no effect on them
        for (int k = 0; k < 16; k++) run_instr(16'h9509 ^ (16'h1 << k), 16'h0300 + 16'(k));
        run_instr(16'h0000, 16'h0111);

        // R4 R5 R6: nested calls stack downward
        run_instr(16'h9509, 16'h0100);
        chk("R6 sp after first call", dbg_sp, 16'hFFFD);
        run_instr(16'h9509, 16'h02F0);
        run_instr(16'h0000, 16'h0055);
        run_instr(16'h9509, 16'h0381);
        run_instr(16'h9509, 16'h03A0);
        chk("R6 sp after four calls", dbg_sp, 16'hFFF7);
        chk("R8 no rd/wr overlap", rw_clash, 0);

        // R1: reset in the middle of the push sequence
        repeat (9) @(posedge clk);
        #1;
        rst = 1'b1;
        @(posedge clk); #1;
        chk("R1 mid-call reset pc", dbg_pc, 16'h0000);
        chk("R1 mid-call reset sp", dbg_sp, 16'hFFFF);
        chk("R1 mid-call reset no write", mem_wr, 1'b0);
        rst = 1'b0;
        run_instr(16'h9508, 16'h0000);
        run_instr(16'h950B, 16'h0000);
        chk("R8 no rd/wr overlap at end", rw_clash, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule